// File: doc/BRIEF.md
# Pin-Controller Bank with Atomic Bit Writes

This block is one bank of 32 general-purpose pins, grouped into four ports of eight pins. For every port, a bus master can choose per pin whether the pad belongs to the bank (GPIO mode) or to another on-chip function (alternate mode). In GPIO mode it can also set the pin's drive enable and output level. The block also captures the pad levels through a two-flop synchronizer into a read-only input register. The pin index is `port*8 + bit`, so pad bit `n` belongs to port `n/8`, bit `n%8`.

Writes happen on the clock edge while `we_i` is high. Read data is combinational from `addr_i`. Register address bits: [1:0] must be zero, [3:2] select the port, [6:4] select the group, and bit 7 selects the masked alias. The groups are 0 = pin ownership, 1 = drive enable, 2 = output level, 3 = input. In the masked alias, software can change any subset of one port's pins in a single write, with no read-modify-write and no race against other agents. The bank occupies a 0x100-byte window, so several banks can be placed side by side.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every ownership, drive-enable and output-level bit is 0. Every pad then follows the alternate-function inputs: `pad_o = alt_out_i` and `pad_oe_o = alt_oe_i`.
- R2: A plain write (addr bit 7 = 0, addr[1:0] = 0) to group 0, 1 or 2 replaces all eight bits of the addressed port's register with wdata[7:0]. wdata[31:8] is ignored. A read of that address returns the register in bits [7:0] and zeros in bits [31:8].
- R3: A write to the masked alias (address = plain address + 0x80) uses wdata[15:8] as per-bit enables and wdata[7:0] as new values. Bits whose enable is 1 take the new value, and bits whose enable is 0 keep their old value.
- R4: For each pin whose ownership bit is 1, `pad_o` equals its output-level bit and `pad_oe_o` equals its drive-enable bit. For each pin whose ownership bit is 0, `pad_o` equals `alt_out_i` and `pad_oe_o` equals `alt_oe_i`.
- R5: A read of group 3 (plain address 0x30 + port*4) returns the port's pad levels through a two-flop synchronizer. A pad change set up before clock edge k is first visible after edge k+1.
- R6: The input register is read-only. Plain or masked writes to its address change no register state, and its reads keep tracking the pads.
- R7: Reads of unmapped addresses return 0. Unmapped addresses are: groups 4 to 7, any masked-alias address, and any address with addr[1:0] != 0. Writes to them change no register.
- R8: A write changes only the addressed port's register in the addressed group. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address within the bank window |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pad_i | input | 32 | Pad input levels, asynchronous |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad drive enables |
| alt_out_i | input | 32 | Alternate-function output levels |
| alt_oe_i | input | 32 | Alternate-function drive enables |

## Verification
The properties assume that `pad_i` is quiet around clock edges, so that the synchronizer's two-cycle delay can be stated exactly. They also assume that address and write data are stable whenever `we_i` is sampled. The bench honours both assumptions by changing pads, addresses, data and strobes only on falling edges. It sweeps every port and group with plain and masked patterns, sweeps a set of unmapped addresses, and compares all 32 pads against a bench-side model after each configuration change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    GRP_OWN = 3'd0,
    GRP_DRV = 3'd1,
    GRP_LVL = 3'd2,
    GRP_IN  = 3'd3
  } grp_e;

  localparam int unsigned GRP_LSB   = 4;
  localparam int unsigned GRP_W     = 3;
  localparam int unsigned PORT_LSB  = 2;
  localparam int unsigned ALIAS_BIT = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          masked_i,
  input  logic          wr_own_i,
  input  logic          wr_drv_i,
  input  logic          wr_lvl_i,
  input  logic [PW-1:0] val_i,
  input  logic [PW-1:0] en_i,
  output logic [PW-1:0] own_o,
  output logic [PW-1:0] drv_o,
  output logic [PW-1:0] lvl_o
);
  logic [PW-1:0] own_q, drv_q, lvl_q;

  function automatic logic [PW-1:0] merge(logic [PW-1:0] old, logic [PW-1:0] v,
                                          logic [PW-1:0] en, logic m);
    return m ? ((old & ~en) | (v & en)) : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      drv_q <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_own_i) own_q <= merge(own_q, val_i, en_i, masked_i);
      if (wr_drv_i) drv_q <= merge(drv_q, val_i, en_i, masked_i);
      if (wr_lvl_i) lvl_q <= merge(lvl_q, val_i, en_i, masked_i);
    end
  end

  assign own_o = own_q;
  assign drv_o = drv_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] drv_i,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] alt_out_i,
  input  logic [WIDTH-1:0] alt_oe_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_o[i]    = own_i[i] ? lvl_i[i] : alt_out_i[i];
    assign pad_oe_o[i] = own_i[i] ? drv_i[i] : alt_oe_i[i];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          we_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   alt_out_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   alt_oe_i
);
  localparam int unsigned NPIN   = NUM_PORTS * PORT_W;
  localparam int unsigned PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NPIN-1:0]   own_q, drv_q, lvl_q, in_q;
  logic              alias_hit, aligned;
  logic [GRP_W-1:0]  grp;
  logic [PSEL_W-1:0] port_sel;
  logic [PORT_W-1:0] wval, wen;

  assign alias_hit = addr_i[ALIAS_BIT];
  assign aligned   = (addr_i[PORT_LSB-1:0] == '0);
  assign grp       = addr_i[GRP_LSB +: GRP_W];
  assign port_sel  = addr_i[PORT_LSB +: PSEL_W];
  assign wval      = wdata_i[PORT_W-1:0];
  assign wen       = wdata_i[2*PORT_W-1:PORT_W];

  gpio_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(in_q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = we_i && aligned && (port_sel == PSEL_W'(p));
    gpio_port_regs #(.PW(PORT_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .masked_i(alias_hit),
      .wr_own_i(hit && (grp == GRP_W'(GRP_OWN))),
      .wr_drv_i(hit && (grp == GRP_W'(GRP_DRV))),
      .wr_lvl_i(hit && (grp == GRP_W'(GRP_LVL))),
      .val_i   (wval),
      .en_i    (wen),
      .own_o   (own_q[p*PORT_W +: PORT_W]),
      .drv_o   (drv_q[p*PORT_W +: PORT_W]),
      .lvl_o   (lvl_q[p*PORT_W +: PORT_W])
    );
  end

  // alias addresses are write-only; reads there decode as unmapped
  always_comb begin
    rdata_o = '0;
    if (!alias_hit && aligned) begin
      unique case (grp)
        GRP_W'(GRP_OWN): rdata_o[PORT_W-1:0] = own_q[port_sel*PORT_W +: PORT_W];
        GRP_W'(GRP_DRV): rdata_o[PORT_W-1:0] = drv_q[port_sel*PORT_W +: PORT_W];
        GRP_W'(GRP_LVL): rdata_o[PORT_W-1:0] = lvl_q[port_sel*PORT_W +: PORT_W];
        GRP_W'(GRP_IN):  rdata_o[PORT_W-1:0] = in_q[port_sel*PORT_W +: PORT_W];
        default:         rdata_o = '0;
      endcase
    end
  end

  gpio_pad_mux #(.WIDTH(NPIN)) u_mux (
    .own_i(own_q), .drv_i(drv_q), .lvl_i(lvl_q),
    .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NPIN-1:0]   pad_i,
  input logic [NPIN-1:0]   pad_o,
  input logic [NPIN-1:0]   pad_oe_o,
  input logic [NPIN-1:0]   alt_out_i,
  input logic [NPIN-1:0]   alt_oe_i,
  input logic [NPIN-1:0]   own_q,
  input logic [NPIN-1:0]   drv_q,
  input logic [NPIN-1:0]   lvl_q,
  input logic [NPIN-1:0]   in_q
);
  logic [NPIN-1:0] win, wv;
  logic            rd_mapped, wr_ok;
  logic [1:0]      cyc;

  always_comb begin
    rd_mapped = !addr_i[7] && addr_i[1:0] == 2'b00 && addr_i[6:4] <= 3'd3;
    wr_ok     = we_i && addr_i[1:0] == 2'b00;
    win = '0;
    wv  = '0;
    win[addr_i[3:2]*8 +: 8] = addr_i[7] ? wdata_i[15:8] : 8'hFF;
    wv[addr_i[3:2]*8 +: 8]  = wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  // R3 R8: only enabled bits of the addressed port may change
  a_r3_own_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((own_q ^ $past(own_q)) &
     ~(($past(wr_ok) && $past(addr_i[6:4]) == 3'd0) ? $past(win) : '0)) == '0);
  a_r8_drv_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drv_q ^ $past(drv_q)) &
     ~(($past(wr_ok) && $past(addr_i[6:4]) == 3'd1) ? $past(win) : '0)) == '0);
  a_r3_lvl_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_q ^ $past(lvl_q)) &
     ~(($past(wr_ok) && $past(addr_i[6:4]) == 3'd2) ? $past(win) : '0)) == '0);
  // R2: enabled bits take the written value
  a_r2_lvl_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && addr_i[6:4] == 3'd2) |=> ((lvl_q ^ $past(wv)) & $past(win)) == '0);
  // R4
  a_r4_gpio_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_o ^ lvl_q) | (pad_oe_o ^ drv_q)) & own_q) == '0);
  a_r4_alt_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_o ^ alt_out_i) | (pad_oe_o ^ alt_oe_i)) & ~own_q) == '0);
  // R5
  a_r5_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> in_q == $past(pad_i, 2));
  // R7
  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_mapped |-> rdata_o == '0);
  // R2: upper read bits are zero
  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:8] == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NUM_PORTS*PORT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
  .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
  .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i),
  .own_q(own_q), .drv_q(drv_q), .lvl_q(lvl_q), .in_q(in_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o, pad_i = '0, pad_o, pad_oe_o;
  logic [31:0] alt_out_i = 32'hA5C3_5A3C, alt_oe_i = 32'h0FF0_33CC;

  int checks = 0, fails = 0;
  logic [31:0] m_own = '0, m_drv = '0, m_lvl = '0;

  always #10 clk_i = ~clk_i;

  gpio_bank u_gpio_bank (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // model update straight from R2, R3, R6, R7, R8
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] en, v;
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a[1:0] == 2'b00 && a[6:4] <= 3'd2) begin
      en = '0; v = '0;
      en[a[3:2]*8 +: 8] = a[7] ? d[15:8] : 8'hFF;
      v[a[3:2]*8 +: 8]  = d[7:0];
      case (a[6:4])
        3'd0: m_own = (m_own & ~en) | (v & en);
        3'd1: m_drv = (m_drv & ~en) | (v & en);
        default: m_lvl = (m_lvl & ~en) | (v & en);
      endcase
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < 4; p++) begin
      rd(tag, 8'(8'h00 + p*4), {24'h0, m_own[p*8 +: 8]});
      rd(tag, 8'(8'h10 + p*4), {24'h0, m_drv[p*8 +: 8]});
      rd(tag, 8'(8'h20 + p*4), {24'h0, m_lvl[p*8 +: 8]});
    end
  endtask

  task automatic check_pads(input string tag);
    #1;
    chk(tag, pad_o, (m_own & m_lvl) | (~m_own & alt_out_i));
    chk(tag, pad_oe_o, (m_own & m_drv) | (~m_own & alt_oe_i));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    // R1
    check_all("R1 reset regs");
    check_pads("R1 reset pads");
    for (int p = 0; p < 4; p++) rd("R1 reset input", 8'(8'h30 + p*4), 32'h0);

    // R2 R8: plain writes, garbage in upper bits
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 4; p++) begin
        wr(8'(g*16 + p*4), 32'hDEAD_BE00 | 32'((p*37 + g*91 + 5) & 8'hFF));
        check_all("R2 R8 plain write");
      end
    check_pads("R4 after plain");

    // R3: masked patterns
    for (int k = 0; k < 8; k++)
      for (int g = 0; g < 3; g++)
        for (int p = 0; p < 4; p++) begin
          wr(8'(8'h80 + g*16 + p*4),
             {16'h5555, 8'((8'h01 << k) | (k*17 + p)), 8'(~(k*29 + g*7 + p))});
          rd("R3 masked", 8'(g*16 + p*4),
             {24'h0, (g == 0) ? m_own[p*8 +: 8] : (g == 1) ? m_drv[p*8 +: 8] : m_lvl[p*8 +: 8]});
        end
    check_all("R3 R8 masked sweep");
    wr(8'h84, 32'h0000_00FF); // zero enable: no change
    check_all("R3 zero enable");
    check_pads("R4 after masked");

    // R4: ownership sweep
    for (int p = 0; p < 4; p++) begin
      wr(8'(p*4), 32'h0000_00FF);
      check_pads("R4 port to gpio");
      wr(8'(8'h80 + p*4), 32'h0000_AA00);
      check_pads("R4 mixed ownership");
    end

    // R5: synchronizer latency
    for (int n = 0; n < 4; n++) begin
      logic [31:0] prev, nv;
      prev = pad_i;
      nv = 32'h1357_9BDF ^ (32'h0F0F_0F0F << n) ^ {4{8'(n)}};
      @(negedge clk_i);
      pad_i = nv;
      addr_i = 8'(8'h30 + n*4);
      @(negedge clk_i);
      #1 chk("R5 one edge", rdata_o, {24'h0, prev[n*8 +: 8]});
      @(negedge clk_i);
      #1 chk("R5 two edges", rdata_o, {24'h0, nv[n*8 +: 8]});
    end

    // R6: writes to input register ignored
    wr(8'h30, 32'h0000_00FF ^ {24'h0, pad_i[7:0]});
    wr(8'hB4, 32'h0000_FFFF);
    rd("R6 input readonly", 8'h30, {24'h0, pad_i[7:0]});
    rd("R6 input readonly", 8'h34, {24'h0, pad_i[15:8]});
    check_all("R6 regs unchanged");

    // R7: unmapped reads and writes
    rd("R7 grp4", 8'h40, 32'h0);
    rd("R7 grp7", 8'h7C, 32'h0);
    rd("R7 alias read", 8'h80, 32'h0);
    rd("R7 alias read", 8'hA8, 32'h0);
    rd("R7 misaligned", 8'h01, 32'h0);
    rd("R7 misaligned", 8'h23, 32'h0);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(8'h02, 32'h0000_0000);
    wr(8'h50, 32'h0000_0000);
    wr(8'hE0, 32'h0000_FF00);
    check_all("R7 writes ignored");
    check_pads("R7 pads unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule